// File: doc/BRIEF.md
# Triggered debug trace capture buffer

This block is a 256-entry by 64-bit trace memory with its own capture control and a small register interface. A trace source presents 64-bit records with a valid strobe. Three single-cycle pulses control capture: one arms the buffer, one marks that a programmed event has fired, and one stops capture. Once the buffer is armed and not stopped, each valid record is written at a circular write pointer. Four sticky status flags report what has happened: active, triggered, stopped and wrapped.

Software reaches the block through a four-register bus. The status register shows the flags and the current write pointer. Before arming, software can write this register to clear the flags and to place the write pointer. The access control register holds an entry index and two command bits. The low and high data registers then move a 64-bit entry as two 32-bit halves, in either direction. A read command copies the whole entry into a holding register, so the two half reads always come from the same entry.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the status register (select 0) and the access control register (select 1) both read as zero.
- R2: A start pulse sets the active flag (status bit 0). A record is not captured before the buffer is active, including a record that arrives in the same cycle as the start pulse.
- R3: While active and not stopped, each valid record is stored at the write pointer, and the pointer then advances by one modulo 256.
- R4: An event pulse sets the triggered flag (status bit 1), which stays set.
- R5: A stop pulse while active sets the stopped flag (status bit 2). The record in the same cycle and every later record are dropped, and neither the pointer nor the memory changes.
- R6: The wrapped flag (status bit 3) sets when a record is captured into entry 255.
- R7: The status register reads back the write pointer in bits 15:8, the flags in bits 3:0, and zero in all other bits.
- R8: A status write while inactive replaces the triggered, stopped and wrapped flags with bits 1 to 3 and loads the write pointer from bits 15:8. While active, a status write changes nothing.
- R9: An access control write loads the entry index from bits 7:0. Reading this register returns the index, with both command bits reading as 0.
- R10: An access control write with bit 31 set copies the indexed entry into the holding register. The low data register (select 2) and the high data register (select 3) return the two halves of the holding register, and they keep those values until the next read command, even if memory changes meanwhile.
- R11: After an access control write with bit 30 set, a low-half write followed by a high-half write stores both halves at the index. A high-half write with no low-half write since the last access control write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Trace record valid |
| rec_data | input | 64 | Trace record |
| start_pulse | input | 1 | Single-cycle arming trigger |
| event_pulse | input | 1 | Single-cycle programmed-event indication |
| stop_pulse | input | 1 | Single-cycle stop condition |
| reg_sel | input | 2 | Register select: 0 status, 1 access control, 2 data low, 3 data high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |

## Verification
The hardest situations to reach are the ones where two sources meet in the same cycle. One is a start or stop pulse that arrives together with a valid record. Another is memory changing between the two half reads of a held entry. The bench drives the pulse and the record on the same clock edge, and its reference model decides whether that record belongs in the scoreboard queue. To test the holding register, it reads the low half, then rewrites the same entry through the software path, and then reads the high half, which must still come from the entry as it was at the read command. The pointer is first placed at 250 through a status write, so a short burst crosses entry 255 and sets the wrap flag.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_DLO  = 2'd2,
      SEL_DHI  = 2'd3
   } reg_sel_e;

   localparam int STAT_PTR_LSB = 8;
   localparam int CTRL_WR_BIT  = 30;
   localparam int CTRL_RD_BIT  = 31;

   typedef struct packed {
      logic wrap;
      logic stop;
      logic trig;
      logic act;
   } flags_t;
endpackage

// File: rtl/tcb_capture_ctrl.sv
module tcb_capture_ctrl #(
   parameter int DEPTH = 256,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rec_valid,
   input  logic                start_pulse,
   input  logic                event_pulse,
   input  logic                stop_pulse,
   input  logic                stat_we,
   input  tcb_pkg::flags_t     stat_wflags,
   input  logic [IDX_W-1:0]    stat_wptr,
   output tcb_pkg::flags_t     flags,
   output logic [IDX_W-1:0]    wptr,
   output logic                cap_we
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   assign cap_we = flags.act && !flags.stop && rec_valid && !stop_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         wptr  <= '0;
      end else begin
         if (stat_we && !flags.act) begin
            flags.trig <= stat_wflags.trig;
            flags.stop <= stat_wflags.stop;
            flags.wrap <= stat_wflags.wrap;
            wptr       <= stat_wptr;
         end
         if (start_pulse)               flags.act  <= 1'b1;
         if (event_pulse)               flags.trig <= 1'b1;
         if (stop_pulse && flags.act)   flags.stop <= 1'b1;
         if (cap_we) begin
            wptr <= wptr + 1'b1;
            if (wptr == LAST) flags.wrap <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tcb_store.sv
module tcb_store #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 64,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              cap_we,
   input  logic [IDX_W-1:0]  cap_addr,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              sw_we,
   input  logic [IDX_W-1:0]  sw_addr,
   input  logic [DATA_W-1:0] sw_data,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (cap_we)      mem[cap_addr] <= cap_data;
      else if (sw_we)  mem[sw_addr]  <= sw_data;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_regif.sv
module tcb_regif #(
   parameter int  DEPTH     = 256,
   parameter int  BUS_W     = 32,
   parameter int  DATA_W    = 2 * BUS_W,
   parameter int  IDX_W     = $clog2(DEPTH),
   parameter bit  RDATA_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          reg_sel,
   input  logic                reg_wr,
   input  logic [BUS_W-1:0]    reg_wdata,
   output logic [BUS_W-1:0]    reg_rdata,
   input  tcb_pkg::flags_t     flags,
   input  logic [IDX_W-1:0]    wptr,
   input  logic                cap_we,
   output logic                stat_we,
   output tcb_pkg::flags_t     stat_wflags,
   output logic [IDX_W-1:0]    stat_wptr,
   output logic [IDX_W-1:0]    mem_raddr,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                sw_we,
   output logic [IDX_W-1:0]    sw_addr,
   output logic [DATA_W-1:0]   sw_data
);
   import tcb_pkg::*;

   logic [IDX_W-1:0]  idx;
   logic              wr_mode, lo_ok, pend;
   logic [BUS_W-1:0]  lo_stage;
   logic [DATA_W-1:0] hold, pend_data;
   logic [IDX_W-1:0]  pend_addr;
   logic              wr_ctrl, wr_lo, commit_now, sw_req;
   logic [BUS_W-1:0]  rd_next;

   assign wr_ctrl     = reg_wr && (reg_sel == SEL_CTRL);
   assign wr_lo       = reg_wr && (reg_sel == SEL_DLO) && wr_mode;
   assign commit_now  = reg_wr && (reg_sel == SEL_DHI) && wr_mode && lo_ok;
   assign stat_we     = reg_wr && (reg_sel == SEL_STAT);
   assign stat_wflags = flags_t'(reg_wdata[3:0]);
   assign stat_wptr   = reg_wdata[STAT_PTR_LSB +: IDX_W];
   assign mem_raddr   = reg_wdata[IDX_W-1:0];

   assign sw_req  = pend || commit_now;
   assign sw_we   = sw_req && !cap_we;
   assign sw_addr = pend ? pend_addr : idx;
   assign sw_data = pend ? pend_data : {reg_wdata, lo_stage};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx       <= '0;
         wr_mode   <= 1'b0;
         lo_ok     <= 1'b0;
         lo_stage  <= '0;
         hold      <= '0;
         pend      <= 1'b0;
         pend_addr <= '0;
         pend_data <= '0;
      end else begin
         if (wr_ctrl) begin
            idx     <= reg_wdata[IDX_W-1:0];
            wr_mode <= reg_wdata[CTRL_WR_BIT];
            lo_ok   <= 1'b0;
            if (reg_wdata[CTRL_RD_BIT]) hold <= mem_rdata;
         end
         if (wr_lo) begin
            lo_stage <= reg_wdata;
            lo_ok    <= 1'b1;
         end
         if (commit_now) lo_ok <= 1'b0;
         pend <= sw_req && cap_we;
         if (commit_now && !pend) begin
            pend_addr <= idx;
            pend_data <= {reg_wdata, lo_stage};
         end
      end
   end

   always_comb begin
      rd_next = '0;
      unique case (reg_sel_e'(reg_sel))
         SEL_STAT: begin
            rd_next[3:0]                  = flags;
            rd_next[STAT_PTR_LSB +: IDX_W] = wptr;
         end
         SEL_CTRL: rd_next[IDX_W-1:0] = idx;
         SEL_DLO:  rd_next = hold[BUS_W-1:0];
         SEL_DHI:  rd_next = hold[DATA_W-1:BUS_W];
         default:  rd_next = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_rdata <= '0;
            else        reg_rdata <= rd_next;
         end
      end else begin : g_rd_comb
         assign reg_rdata = rd_next;
      end
   endgenerate
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
   parameter int DEPTH     = 256,
   parameter int BUS_W     = 32,
   parameter int DATA_W    = 64,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_valid,
   input  logic [DATA_W-1:0] rec_data,
   input  logic              start_pulse,
   input  logic              event_pulse,
   input  logic              stop_pulse,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DATA_W != 2 * BUS_W) begin : g_bad_width
         $error("trace_capture_buf: DATA_W must be twice BUS_W");
      end
      if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("trace_capture_buf: DEPTH must be a power of two");
      end
      if (IDX_W + tcb_pkg::STAT_PTR_LSB > BUS_W) begin : g_bad_ptr
         $error("trace_capture_buf: write pointer does not fit the status register");
      end
   endgenerate

   tcb_pkg::flags_t   st_flags, stat_wflags;
   logic [IDX_W-1:0]  wptr, stat_wptr, mem_raddr, sw_addr;
   logic              cap_we, stat_we, sw_we;
   logic [DATA_W-1:0] mem_rdata, sw_data;

   tcb_capture_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid),
      .start_pulse(start_pulse), .event_pulse(event_pulse), .stop_pulse(stop_pulse),
      .stat_we(stat_we), .stat_wflags(stat_wflags), .stat_wptr(stat_wptr),
      .flags(st_flags), .wptr(wptr), .cap_we(cap_we)
   );

   tcb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .cap_we(cap_we), .cap_addr(wptr), .cap_data(rec_data),
      .sw_we(sw_we), .sw_addr(sw_addr), .sw_data(sw_data),
      .raddr(mem_raddr), .rdata(mem_rdata)
   );

   tcb_regif #(.DEPTH(DEPTH), .BUS_W(BUS_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
               .RDATA_REG(RDATA_REG)) u_regif (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .flags(st_flags), .wptr(wptr), .cap_we(cap_we),
      .stat_we(stat_we), .stat_wflags(stat_wflags), .stat_wptr(stat_wptr),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .sw_we(sw_we), .sw_addr(sw_addr), .sw_data(sw_data)
   );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input tcb_pkg::flags_t  flags,
   input logic [IDX_W-1:0] wptr,
   input logic             cap_we,
   input logic             stat_we
);
   localparam logic [IDX_W-1:0] LAST = '1;

   AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags.act |=> flags.act); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_we |=> (wptr - $past(wptr)) == IDX_W'(1)); // R3
   AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags.act && flags.trig |=> flags.trig); // R4
   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      flags.stop && !stat_we |=> $stable(wptr)); // R5
   AST_NO_CAPTURE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      flags.stop |-> !cap_we); // R5
   AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cap_we && (wptr == LAST) |=> flags.wrap); // R6
   AST_STATUS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      flags.act && !cap_we |=> $stable(wptr)); // R8
endmodule

bind trace_capture_buf tcb_checker #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flags(st_flags), .wptr(wptr),
   .cap_we(cap_we), .stat_we(stat_we)
);

// File: tb/trace_capture_buf_tb.sv
`timescale 1ns/1ps
module trace_capture_buf_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rec_valid = 1'b0;
   logic [63:0] rec_data = '0;
   logic        start_pulse = 1'b0, event_pulse = 1'b0, stop_pulse = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   // bench reference model and scoreboard
   bit          m_act = 1'b0, m_stop = 1'b0;
   logic [7:0]  m_wptr = '0;
   logic [7:0]  q_idx[$];
   logic [63:0] q_dat[$];

   trace_capture_buf u_dut (
      .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
      .start_pulse(start_pulse), .event_pulse(event_pulse), .stop_pulse(stop_pulse),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [31:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic read_entry(input logic [7:0] idx, output logic [63:0] d);
      logic [31:0] lo, hi;
      reg_write(2'd1, 32'h8000_0000 | 32'(idx));
      reg_read(2'd2, lo);
      reg_read(2'd3, hi);
      d = {hi, lo};
   endtask

   task automatic write_entry(input logic [7:0] idx, input logic [63:0] d);
      reg_write(2'd1, 32'h4000_0000 | 32'(idx));
      reg_write(2'd2, d[31:0]);
      reg_write(2'd3, d[63:32]);
   endtask

   // driver: drives a burst of back-to-back records and pushes expectations
   task automatic send_burst(input int n, input logic [31:0] tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rec_valid = 1'b1;
         rec_data  = {tag, 32'(i) * 32'h0101_0003};
         if (m_act && !m_stop) begin
            q_idx.push_back(m_wptr);
            q_dat.push_back(rec_data);
            m_wptr = m_wptr + 8'd1;
         end
      end
      @(negedge clk);
      rec_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      logic [63:0] d, ent_a, ent_b, ent_c;
      ent_a = 64'hAAAA_1111_2222_3333;
      ent_b = 64'hBBBB_4444_5555_6666;
      ent_c = 64'hCCCC_7777_8888_9999;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(2'd0, v); chk("R1 status after reset", 64'(v), 64'h0);
      reg_read(2'd1, v); chk("R1 access ctrl after reset", 64'(v), 64'h0);

      // R8: status write while inactive places pointer and flags
      reg_write(2'd0, 32'h0000_FA0E);
      reg_read(2'd0, v); chk("R8 R7 status write inactive", 64'(v), 64'h0000_FA0E);
      reg_write(2'd0, 32'hFFFF_FA00);
      reg_read(2'd0, v); chk("R8 R7 flags cleared, upper bits zero", 64'(v), 64'h0000_FA00);
      m_wptr = 8'hFA;

      // R2: records before arming are dropped
      send_burst(2, 32'hDEAD_0000);
      reg_read(2'd0, v); chk("R2 no capture before start", 64'(v), 64'h0000_FA00);

      // R11: software write path
      write_entry(8'd4, ent_a);
      write_entry(8'd6, ent_b);
      reg_write(2'd1, 32'h4000_0006);
      reg_write(2'd3, 32'h0BAD_0BAD);
      read_entry(8'd6, d); chk("R11 high-only write ignored", d, ent_b);
      read_entry(8'd4, d); chk("R11 R10 written entry reads back", d, ent_a);

      // R4: programmed event
      @(negedge clk); event_pulse = 1'b1;
      @(negedge clk); event_pulse = 1'b0;
      reg_read(2'd0, v); chk("R4 triggered set", 64'(v), 64'h0000_FA02);

      // R2: start together with a record, that record is dropped
      @(negedge clk); start_pulse = 1'b1; rec_valid = 1'b1; rec_data = 64'hFEED;
      @(negedge clk); start_pulse = 1'b0; rec_valid = 1'b0;
      m_act = 1'b1;
      reg_read(2'd0, v); chk("R2 active, coincident record dropped", 64'(v), 64'h0000_FA03);

      // R3 R6: burst of 10 crosses entry 255
      send_burst(10, 32'h5A5A_0000);
      reg_read(2'd0, v); chk("R3 R6 pointer advanced and wrapped", 64'(v), 64'h0000_040B);

      // R8: status write while active ignored
      reg_write(2'd0, 32'h0000_0000);
      reg_read(2'd0, v); chk("R8 status write ignored while active", 64'(v), 64'h0000_040B);

      // R5: stop with a coincident record, then more records
      @(negedge clk); stop_pulse = 1'b1; rec_valid = 1'b1; rec_data = 64'hBEEF;
      @(negedge clk); stop_pulse = 1'b0; rec_valid = 1'b0;
      m_stop = 1'b1;
      reg_read(2'd0, v); chk("R5 stopped set", 64'(v), 64'h0000_040F);
      send_burst(3, 32'h7777_0000);
      reg_read(2'd0, v); chk("R5 pointer frozen after stop", 64'(v), 64'h0000_040F);
      read_entry(8'd4, d); chk("R5 entry 4 untouched after stop", d, ent_a);

      // monitor: pop scoreboard and compare captured entries
      chk("R3 scoreboard depth", 64'(q_idx.size()), 64'd10);
      while (q_idx.size() > 0) begin
         logic [7:0]  ix;
         logic [63:0] ex;
         ix = q_idx.pop_front();
         ex = q_dat.pop_front();
         read_entry(ix, d);
         chk($sformatf("R3 captured entry %0d", ix), d, ex);
      end

      // R10: holding register stays consistent across a memory update
      reg_write(2'd1, 32'h8000_0006);
      reg_read(2'd2, v); chk("R10 low half of held entry", 64'(v), 64'(ent_b[31:0]));
      write_entry(8'd6, ent_c);
      reg_read(2'd3, v); chk("R10 high half from held entry", 64'(v), 64'(ent_b[63:32]));
      reg_read(2'd1, v); chk("R9 index readback, command bits zero", 64'(v), 64'h6);
      read_entry(8'd6, d); chk("R11 overwrite committed", d, ent_c);
      reg_write(2'd1, 32'h0000_00FF);
      reg_read(2'd1, v); chk("R9 index 255 readback", 64'(v), 64'hFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule